// File: doc/BRIEF.md
# Security-Aware Exception Mode Router

This block sits beside a processor's exception entry logic. On every clock it looks at a vector of pending exception requests. If any is present it picks the most urgent one and works out three things: the processor mode the exception enters, the security state the core is in afterwards, and the new values of the asynchronous-abort mask (A) and the fast-interrupt mask (F). A small routing configuration, held inside the block, can steer external aborts, IRQs and FIQs into a monitor mode instead of their usual handler modes.

The block also holds the A and F mask bits and filters software writes to them. Secure software may always change them. Non-secure software may change each bit only when the matching permission bit in the configuration allows it. The results are registered, and a one-cycle `exc_valid` pulse marks the cycle in which a routing decision appears on the outputs.

Top module: `exc_mode_router`

## Requirements
- R1: A reset request (`exc_req[0]`) enters supervisor mode (`10011`), sets A=1 and F=1, leaves the core secure (`exc_ns`=0) and clears all five configuration bits to 0.
- R2: An undefined-instruction request (`exc_req[5]`) enters mode `11011`. A supervisor call (`exc_req[6]`) enters mode `10011`. Neither changes A or F.
- R3: A secure monitor call (`exc_req[7]`) enters monitor mode (`10110`) and sets F=1.
- R4: An external abort (`exc_req[1]`) enters abort mode (`10111`) with F unchanged when the external-abort routing bit (`cfg_wdata[0]`) is 0. When that bit is 1 it enters monitor mode and sets F=1.
- R5: An internal abort (`exc_req[4]`) always enters abort mode with F unchanged, whatever the configuration bits hold.
- R6: An IRQ (`exc_req[3]`) enters IRQ mode (`10010`) with F unchanged when the IRQ routing bit (`cfg_wdata[1]`) is 0. When that bit is 1 it enters monitor mode and sets F=1.
- R7: A FIQ (`exc_req[2]`) enters FIQ mode (`10001`) when the FIQ routing bit (`cfg_wdata[2]`) is 0, and monitor mode when it is 1. Both cases set F=1.
- R8: Any entry to monitor mode, and any reset request, drives `exc_ns` to 0. Every other exception copies `cur_ns` into `exc_ns`.
- R9: A software mask write (`sw_we`) made in a cycle with no exception request updates A from `sw_a` when `cur_ns`=0 or the A-permission bit (`cfg_wdata[3]`) is 1. It updates F from `sw_f` when `cur_ns`=0 or the F-permission bit (`cfg_wdata[4]`) is 1. Otherwise the write leaves that bit unchanged.
- R10: When several requests are present together, the lowest set index wins: reset, external abort, FIQ, IRQ, internal abort, undefined, supervisor call, monitor call.
- R11: Results appear on the first clock edge after the request, together with a one-cycle `exc_valid` pulse. Without a request, `exc_valid` is 0 and `exc_mode`/`exc_ns` hold their values. A software mask write in a cycle that has an exception request is ignored.
- R12: While `rst_n` is 0 the block returns synchronously to `exc_valid`=0, mode `10011`, `exc_ns`=0, A=F=1 and configuration 0.
- R13: A configuration write (`cfg_we`) takes effect from the next cycle. A request in the same cycle is routed with the old configuration, and a reset request in that cycle overrides the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| exc_req | input | 8 | Exception requests, index order as in R10 |
| cur_ns | input | 1 | Current security state, 1 = non-secure |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 5 | Configuration: [0] abort route, [1] IRQ route, [2] FIQ route, [3] A permission, [4] F permission |
| sw_we | input | 1 | Software mask write strobe |
| sw_a | input | 1 | Requested A mask value |
| sw_f | input | 1 | Requested F mask value |
| exc_valid | output | 1 | One-cycle pulse: a routing decision is shown |
| exc_mode | output | 5 | Target mode code |
| exc_ns | output | 1 | Security state after the exception |
| mask_a | output | 1 | Current A mask bit |
| mask_f | output | 1 | Current F mask bit |

## Verification
Every result is due exactly one rising edge after the inputs that cause it: the mode, the security state, the valid pulse, the mask bits after an exception or a software write, and a new configuration. The driver applies inputs on the falling edge and queues its expectation for that edge. The monitor reads the outputs shortly after the next rising edge and takes one queued item per cycle, so each expectation is matched against the cycle it belongs to. Configuration changes are checked through the routing of a later request, and a refused mask write is checked through the mask outputs in the cycle after it.

// File: rtl/exr_pkg.sv
// Package: shared constants for the exception mode router.
// Assumes request index order equals priority order (index 0 most urgent).
package exr_pkg;
    localparam int NUM_SRC = 8;
    localparam int MODE_W  = 5;
    localparam int CFG_W   = 5;

    // request indices, lowest index wins
    localparam int SRC_RST  = 0;
    localparam int SRC_EABT = 1;
    localparam int SRC_FIQ  = 2;
    localparam int SRC_IRQ  = 3;
    localparam int SRC_IABT = 4;
    localparam int SRC_UND  = 5;
    localparam int SRC_SVC  = 6;
    localparam int SRC_SMC  = 7;

    // configuration bit positions
    localparam int CFG_EA = 0;
    localparam int CFG_IR = 1;
    localparam int CFG_FI = 2;
    localparam int CFG_AW = 3;
    localparam int CFG_FW = 4;

    typedef enum logic [MODE_W-1:0] {
        MODE_FIQ = 5'b10001,
        MODE_IRQ = 5'b10010,
        MODE_SVC = 5'b10011,
        MODE_MON = 5'b10110,
        MODE_ABT = 5'b10111,
        MODE_UND = 5'b11011
    } mode_e;
endpackage

// File: rtl/exr_prio_pick.sv
// Module: fixed-priority picker; grants the lowest-index active request.
// Assumes nothing about how many requests are active at once.
module exr_prio_pick #(
    parameter int N = 8
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant
);
    logic [N:0] seen;

    assign seen[0] = 1'b0;
    // chain of "higher-priority request seen" flags
    for (genvar i = 0; i < N; i++) begin : g_chain
        assign grant[i]  = req[i] & ~seen[i];
        assign seen[i+1] = seen[i] | req[i];
    end
endmodule

// File: rtl/exr_route_dec.sv
// Module: maps a one-hot grant and the routing configuration to a mode,
// a monitor-entry flag and an F-mask set flag.
// Assumes grant is one-hot or zero.
module exr_route_dec
    import exr_pkg::*;
(
    input  logic [NUM_SRC-1:0] grant,
    input  logic [CFG_W-1:0]   cfg,
    output mode_e              mode,
    output logic               to_secure,
    output logic               set_f
);
    // decode the granted source into its target mode and side effects
    always_comb begin
        mode      = MODE_SVC;
        to_secure = 1'b0;
        set_f     = 1'b0;
        unique case (1'b1)
            grant[SRC_RST]: begin
                mode = MODE_SVC; to_secure = 1'b1; set_f = 1'b1;
            end
            grant[SRC_EABT]: begin
                mode      = cfg[CFG_EA] ? MODE_MON : MODE_ABT;
                to_secure = cfg[CFG_EA];
                set_f     = cfg[CFG_EA];
            end
            grant[SRC_FIQ]: begin
                mode      = cfg[CFG_FI] ? MODE_MON : MODE_FIQ;
                to_secure = cfg[CFG_FI];
                set_f     = 1'b1;
            end
            grant[SRC_IRQ]: begin
                mode      = cfg[CFG_IR] ? MODE_MON : MODE_IRQ;
                to_secure = cfg[CFG_IR];
                set_f     = cfg[CFG_IR];
            end
            grant[SRC_IABT]: mode = MODE_ABT;
            grant[SRC_UND]:  mode = MODE_UND;
            grant[SRC_SVC]:  mode = MODE_SVC;
            grant[SRC_SMC]: begin
                mode = MODE_MON; to_secure = 1'b1; set_f = 1'b1;
            end
            default: mode = MODE_SVC;
        endcase
    end
endmodule

// File: rtl/exr_mask_ctl.sv
// Module: holds the A and F mask bits; applies exception side effects and
// filters software writes by security state and permission bits.
// Assumes exception side effects take precedence over software writes.
module exr_mask_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic exc_any,
    input  logic exc_rst,
    input  logic set_f,
    input  logic sw_we,
    input  logic sw_a,
    input  logic sw_f,
    input  logic cur_ns,
    input  logic perm_a,
    input  logic perm_f,
    output logic mask_a,
    output logic mask_f
);
    logic wr_a_ok, wr_f_ok;

    assign wr_a_ok = sw_we & ~exc_any & (~cur_ns | perm_a);
    assign wr_f_ok = sw_we & ~exc_any & (~cur_ns | perm_f);

    // update mask bits from exceptions or permitted software writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_a <= 1'b1;
            mask_f <= 1'b1;
        end else if (exc_any) begin
            if (exc_rst) mask_a <= 1'b1;
            if (set_f)   mask_f <= 1'b1;
        end else begin
            if (wr_a_ok) mask_a <= sw_a;
            if (wr_f_ok) mask_f <= sw_f;
        end
    end

    // R9: a refused non-secure write leaves the bits as they were
    a_r9_a_locked: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && sw_we && cur_ns && !perm_a && !exc_any) |-> mask_a == $past(mask_a));
    a_r9_f_locked: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && sw_we && cur_ns && !perm_f && !exc_any) |-> mask_f == $past(mask_f));
endmodule

// File: rtl/exc_mode_router.sv
// Module: top of the exception mode router. Picks the most urgent request,
// routes it with the held configuration and registers mode, security state
// and valid pulse one cycle after the request.
// Assumes cur_ns and the requests are synchronous to clk.
module exc_mode_router
    import exr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] exc_req,
    input  logic               cur_ns,
    input  logic               cfg_we,
    input  logic [CFG_W-1:0]   cfg_wdata,
    input  logic               sw_we,
    input  logic               sw_a,
    input  logic               sw_f,
    output logic               exc_valid,
    output logic [MODE_W-1:0]  exc_mode,
    output logic               exc_ns,
    output logic               mask_a,
    output logic               mask_f
);
    logic [NUM_SRC-1:0] grant;
    logic [CFG_W-1:0]   cfg_q;
    mode_e              dec_mode;
    logic               dec_secure, dec_set_f, exc_any;

    assign exc_any = |exc_req;

    exr_prio_pick #(.N(NUM_SRC)) u_pick (
        .req   (exc_req),
        .grant (grant)
    );

    exr_route_dec u_dec (
        .grant     (grant),
        .cfg       (cfg_q),
        .mode      (dec_mode),
        .to_secure (dec_secure),
        .set_f     (dec_set_f)
    );

    exr_mask_ctl u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .exc_any (exc_any),
        .exc_rst (grant[SRC_RST]),
        .set_f   (dec_set_f),
        .sw_we   (sw_we),
        .sw_a    (sw_a),
        .sw_f    (sw_f),
        .cur_ns  (cur_ns),
        .perm_a  (cfg_q[CFG_AW]),
        .perm_f  (cfg_q[CFG_FW]),
        .mask_a  (mask_a),
        .mask_f  (mask_f)
    );

    // hold the routing configuration; a reset request clears it
    always_ff @(posedge clk) begin
        if (!rst_n || grant[SRC_RST]) cfg_q <= '0;
        else if (cfg_we)              cfg_q <= cfg_wdata;
    end

    // register the routing decision and its valid pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exc_valid <= 1'b0;
            exc_mode  <= MODE_SVC;
            exc_ns    <= 1'b0;
        end else begin
            exc_valid <= exc_any;
            if (exc_any) begin
                exc_mode <= dec_mode;
                exc_ns   <= dec_secure ? 1'b0 : cur_ns;
            end
        end
    end

    // R10: at most one source granted
    a_r10_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    // R8: monitor entry always ends secure
    a_r8_mon_secure: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid && exc_mode == MODE_MON) |-> !exc_ns);
    // R3: monitor entry always leaves F set
    a_r3_mon_masks_f: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid && exc_mode == MODE_MON) |-> mask_f);
    // R11: valid pulse only follows a request
    a_r11_valid_cause: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |-> ($past(rst_n) && $past(exc_any)));
    // R11: mode holds when no request was present
    a_r11_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(exc_any)) |-> $stable(exc_mode));
endmodule

// File: tb/exc_mode_router_bench.sv
module exc_mode_router_bench;
    localparam logic [4:0] M_FIQ = 5'b10001, M_IRQ = 5'b10010, M_SVC = 5'b10011,
                           M_MON = 5'b10110, M_ABT = 5'b10111, M_UND = 5'b11011;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] exc_req = '0;
    logic       cur_ns = 1'b0, cfg_we = 1'b0, sw_we = 1'b0, sw_a = 1'b0, sw_f = 1'b0;
    logic [4:0] cfg_wdata = '0;
    logic       exc_valid, exc_ns, mask_a, mask_f;
    logic [4:0] exc_mode;

    typedef struct {
        logic       v;
        logic [4:0] mode;
        logic       ns;
        logic       a;
        logic       f;
        string      tag;
    } exp_t;

    exp_t q[$];
    int compared = 0, mismatched = 0;
    bit done = 1'b0;

    // reference state kept from the requirements
    logic [4:0] m_mode = M_SVC, m_cfg = '0;
    logic       m_ns = 1'b0, m_a = 1'b1, m_f = 1'b1;

    always #5 clk = ~clk;

    exc_mode_router u_exc_mode_router (
        .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .cur_ns(cur_ns),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .sw_we(sw_we), .sw_a(sw_a),
        .sw_f(sw_f), .exc_valid(exc_valid), .exc_mode(exc_mode),
        .exc_ns(exc_ns), .mask_a(mask_a), .mask_f(mask_f)
    );

    task automatic cmp(input exp_t e);
        compared++;
        if (exc_valid !== e.v || exc_mode !== e.mode || exc_ns !== e.ns ||
            mask_a !== e.a || mask_f !== e.f) begin
            mismatched++;
            $display("FAIL %s: got v=%b mode=%b ns=%b a=%b f=%b, want v=%b mode=%b ns=%b a=%b f=%b",
                     e.tag, exc_valid, exc_mode, exc_ns, mask_a, mask_f,
                     e.v, e.mode, e.ns, e.a, e.f);
        end
    endtask

    // driver: apply one cycle of inputs on the falling edge, queue expectation
    task automatic step(input logic [7:0] req, input logic ns, input logic swe,
                        input logic swa, input logic swf, input logic cwe,
                        input logic [4:0] cwd, input string tag);
        exp_t e;
        bit v;
        @(negedge clk);
        exc_req = req; cur_ns = ns; sw_we = swe; sw_a = swa; sw_f = swf;
        cfg_we = cwe; cfg_wdata = cwd;
        v = (req != 0);
        if (v) begin
            m_ns = ns;
            if (req[0]) begin m_mode = M_SVC; m_ns = 0; m_a = 1; m_f = 1; end
            else if (req[1]) begin
                if (m_cfg[0]) begin m_mode = M_MON; m_ns = 0; m_f = 1; end
                else m_mode = M_ABT;
            end else if (req[2]) begin
                m_f = 1;
                if (m_cfg[2]) begin m_mode = M_MON; m_ns = 0; end
                else m_mode = M_FIQ;
            end else if (req[3]) begin
                if (m_cfg[1]) begin m_mode = M_MON; m_ns = 0; m_f = 1; end
                else m_mode = M_IRQ;
            end else if (req[4]) m_mode = M_ABT;
            else if (req[5]) m_mode = M_UND;
            else if (req[6]) m_mode = M_SVC;
            else begin m_mode = M_MON; m_ns = 0; m_f = 1; end
        end else if (swe) begin
            if (!ns || m_cfg[3]) m_a = swa;
            if (!ns || m_cfg[4]) m_f = swf;
        end
        if (req[0]) m_cfg = '0;
        else if (cwe) m_cfg = cwd;
        e.v = v; e.mode = m_mode; e.ns = m_ns; e.a = m_a; e.f = m_f; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic idle(input string tag);
        step(8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0, tag);
    endtask

    // monitor: one comparison per cycle, shortly after the rising edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) cmp(q.pop_front());
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: got no end, want end of run");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        exp_t r;
        // drive some non-reset activity during reset to check it is overridden
        repeat (3) @(negedge clk);
        exc_req = 8'h08; sw_we = 1; cfg_we = 1; cfg_wdata = 5'h1f;
        @(negedge clk);
        exc_req = '0; sw_we = 0; cfg_we = 0; cfg_wdata = '0;
        @(negedge clk);
        rst_n = 1'b1;
        r.v = 0; r.mode = M_SVC; r.ns = 0; r.a = 1; r.f = 1; r.tag = "R12 reset state";
        #1; cmp(r);

        // R12: config cleared by rst_n: IRQ goes to IRQ mode
        step(8'h08, 1'b1, 0, 0, 0, 0, 0, "R12 R6 IRQ after reset, cfg clear");
        idle("R11 hold after IRQ");
        // R9: secure software clears both masks
        step(8'h00, 1'b0, 1, 0, 0, 0, 0, "R9 secure write");
        // R2: undefined and SVC leave F at 0
        step(8'h20, 1'b1, 0, 0, 0, 0, 0, "R2 undefined");
        step(8'h40, 1'b1, 0, 0, 0, 0, 0, "R2 supervisor call");
        // R5: internal abort, then R4 external abort with EA=0
        step(8'h10, 1'b1, 0, 0, 0, 0, 0, "R5 internal abort");
        step(8'h02, 1'b1, 0, 0, 0, 0, 0, "R4 ext abort EA=0");
        // R6 IRQ with route bit 0 keeps F
        step(8'h08, 1'b0, 0, 0, 0, 0, 0, "R6 IRQ route 0");
        // R9: non-secure write refused with perms 0
        step(8'h00, 1'b1, 1, 1, 1, 0, 0, "R9 ns write refused");
        // R7: FIQ route 0 sets F, stays ns
        step(8'h04, 1'b1, 0, 0, 0, 0, 0, "R7 FIQ route 0");
        // R9: secure write clears F again
        step(8'h00, 1'b0, 1, 0, 0, 0, 0, "R9 secure write 2");
        // R3: monitor call from ns
        step(8'h80, 1'b1, 0, 0, 0, 0, 0, "R3 R8 monitor call");
        step(8'h00, 1'b0, 1, 0, 0, 0, 0, "R9 secure write 3");
        // R13: config write with same-cycle abort uses old config
        step(8'h02, 1'b1, 0, 0, 0, 1, 5'b00111, "R13 abort with cfg write");
        step(8'h02, 1'b1, 0, 0, 0, 0, 0, "R4 R8 ext abort EA=1");
        step(8'h00, 1'b0, 1, 0, 0, 0, 0, "R9 secure write 4");
        step(8'h08, 1'b1, 0, 0, 0, 0, 0, "R6 R8 IRQ route 1");
        step(8'h00, 1'b0, 1, 0, 0, 0, 0, "R9 secure write 5");
        step(8'h04, 1'b1, 0, 0, 0, 0, 0, "R7 FIQ route 1");
        step(8'h10, 1'b1, 0, 0, 0, 0, 0, "R5 internal abort with cfg set");
        // R9: grant A permission only
        step(8'h00, 1'b0, 0, 0, 0, 1, 5'b01000, "R13 cfg A perm");
        step(8'h00, 1'b1, 1, 0, 0, 0, 0, "R9 ns write A only");
        step(8'h00, 1'b0, 0, 0, 0, 1, 5'b10000, "R13 cfg F perm");
        step(8'h00, 1'b1, 1, 1, 0, 0, 0, "R9 ns write F only");
        // R11: write ignored when a request is present
        step(8'h20, 1'b0, 1, 0, 1, 0, 0, "R11 write ignored with request");
        // R10: priority patterns
        step(8'h0c, 1'b1, 0, 0, 0, 1, 5'b00000, "R10 FIQ over IRQ");
        step(8'h18, 1'b1, 0, 0, 0, 0, 0, "R10 IRQ over internal abort");
        step(8'hf0, 1'b1, 0, 0, 0, 0, 0, "R10 internal abort over rest");
        step(8'h06, 1'b1, 0, 0, 0, 0, 0, "R10 ext abort over FIQ");
        step(8'h00, 1'b0, 1, 0, 0, 1, 5'b11111, "R9 clear masks, set cfg");
        // R1: reset request beats everything and clears config; R13 override
        step(8'hff, 1'b1, 0, 0, 0, 1, 5'b11111, "R1 R10 reset request");
        step(8'h08, 1'b1, 0, 0, 0, 0, 0, "R1 cfg cleared, IRQ mode");
        step(8'h00, 1'b1, 1, 0, 0, 0, 0, "R1 R9 perms cleared");
        idle("R11 final idle");
        idle("R11 final idle 2");
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule